// File: doc/BRIEF.md
# Power-State-Aware Reset Controller

This block produces the reset lines for the sub-blocks of a bus-attached network controller. These sub-blocks are the wake-event logic, the PHY, the EEPROM loader, the configuration registers, the MAC, the DMA engines and the system control registers. The system control registers get two lines: one for bits that a software reset clears, and one for bits that it must keep. The identification registers get a line of their own. Each line is active-low. A fixed reset map decides which reset sources reach which line.

The sources are:
- a power-on timer that runs off whichever supply powers the device;
- the host bus reset;
- a reset on the D3-hot to D0-uninitialized transition;
- a self-clearing software reset bit;
- a self-clearing PHY reset bit;
- a write of the PHY basic control register.

The host reset acts as a level while the device is in a D0 state. In a D3 state it acts only through its rising edge. Two configuration inputs shape the map. One enables cold-state wake, which shields the wake logic from the host reset. The other records whether the PHY is reset on entry to D3 hot, which decides whether it is reset again on exit.

Every line asserts asynchronously as soon as its source is active. It releases through a two-flop synchronizer.

Top module: `pm_reset_ctrl`

## Requirements
- R1: Every output reset line is held low while the selected supply is not good. The selected supply is `aux_pwr_ok_i` when `aux_mode_i`=1 and `main_pwr_ok_i` otherwise. The lines stay low until POR_CYCLES = CLK_MHZ*POR_US clocks after that supply is good.
- R2: With `pwr_state_i` at 0 (D0 uninitialized) or 1 (D0 active), a low `host_rst_ni` holds all nine lines low for as long as it stays low. `wake_rst_no` is the exception covered by R8. When the input rises, the lines release.
- R3: With `pwr_state_i` at 2 (D3 hot) or 3 (D3 cold), a low `host_rst_ni` has no effect. Its low-to-high transition fires a pulse of PULSE_CYCLES clocks on the same set of lines as R2.
- R4: A change of `pwr_state_i` from 2 to 0 fires a pulse on `cfg_rst_no`, `mac_rst_no`, `dma_rst_no`, `sysreg_rst_no` and `nasr_rst_no`. It leaves `eep_rst_no`, `id_rst_no` and `wake_rst_no` high. A change from 3 to 0 fires nothing.
- R5: A one-cycle `sw_rst_set_i` fires a PULSE_CYCLES pulse on `mac_rst_no`, `dma_rst_no` and `sysreg_rst_no` only; `nasr_rst_no` stays high. `sw_pend_o` is high during the pulse and clears by itself when it ends.
- R6: A one-cycle `phy_rst_set_i` fires a pulse on `phy_rst_no` only. `phy_pend_o` is high during the pulse and then clears by itself.
- R7: `phy_bcr_wr_i` with `phy_bcr_bit15_i`=1 fires a pulse on `phy_rst_no` only. The same write with bit 15 at 0 has no effect.
- R8: While `cold_wake_en_i`=1, the host reset (level or edge) leaves `wake_rst_no` high.
- R9: On entry to state 2 with `phy_off_d3_i`=1, a pulse fires on `phy_rst_no` and a flag is set. On the later change from 2 to 0, `phy_rst_no` pulses as well. With `phy_off_d3_i`=0, neither event touches the PHY.
- R10: A line goes low in the same cycle its source becomes active. It rises on the second clock edge after the source ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the controller |
| main_pwr_ok_i | input | 1 | Main supply good (asynchronous) |
| aux_pwr_ok_i | input | 1 | Auxiliary supply good (asynchronous) |
| aux_mode_i | input | 1 | 1: device runs from the auxiliary supply |
| host_rst_ni | input | 1 | Host bus reset, active low (asynchronous) |
| pwr_state_i | input | 2 | 0 D0 uninit, 1 D0 active, 2 D3 hot, 3 D3 cold |
| cold_wake_en_i | input | 1 | Cold-state wake support configured |
| phy_off_d3_i | input | 1 | Reset the PHY on entry to D3 hot |
| sw_rst_set_i | input | 1 | Write of 1 to the software reset bit |
| phy_rst_set_i | input | 1 | Write of 1 to the PHY reset bit |
| phy_bcr_wr_i | input | 1 | Write strobe of the PHY basic control register |
| phy_bcr_bit15_i | input | 1 | Bit 15 of that write |
| sw_pend_o | output | 1 | Software reset bit, self-clearing |
| phy_pend_o | output | 1 | PHY reset bit, self-clearing |
| wake_rst_no | output | 1 | Wake-event logic reset |
| phy_rst_no | output | 1 | PHY reset |
| eep_rst_no | output | 1 | EEPROM loader reset |
| cfg_rst_no | output | 1 | Configuration register reset |
| mac_rst_no | output | 1 | MAC reset |
| dma_rst_no | output | 1 | DMA engine reset |
| sysreg_rst_no | output | 1 | System control register reset |
| nasr_rst_no | output | 1 | Reset of control bits kept across software reset |
| id_rst_no | output | 1 | Reset of EEPROM-loaded identification registers |

## Verification
The assertions take several things for granted.
- `pwr_state_i`, `cold_wake_en_i`, `phy_off_d3_i` and `aux_mode_i` come from logic in the same clock domain, so they are never sampled mid-change.
- Request strobes last a single cycle.
- PULSE_CYCLES is at least 2.

The stimulus keeps within these limits in the following ways.
- All inputs are driven on the falling clock edge.
- Each strobe is held for exactly one cycle.
- Each power-state move is followed by a settling wait longer than any pulse, so one event's pulse never overlaps the next event being checked.

// File: rtl/pm_rst_pkg.sv
package pm_rst_pkg;

  typedef enum logic [1:0] {
    PS_D0U = 2'd0,
    PS_D0A = 2'd1,
    PS_D3H = 2'd2,
    PS_D3C = 2'd3
  } pstate_e;

  // output line index
  localparam int unsigned IDX_WAKE = 0;
  localparam int unsigned IDX_PHY  = 1;
  localparam int unsigned IDX_EEP  = 2;
  localparam int unsigned IDX_CFG  = 3;
  localparam int unsigned IDX_MAC  = 4;
  localparam int unsigned IDX_DMA  = 5;
  localparam int unsigned IDX_SYS  = 6;
  localparam int unsigned IDX_NASR = 7;
  localparam int unsigned IDX_ID   = 8;
  localparam int unsigned NUM_RST  = 9;

  // pulse generator index
  localparam int unsigned PU_HOST   = 0;
  localparam int unsigned PU_D3     = 1;
  localparam int unsigned PU_D3PHY  = 2;
  localparam int unsigned PU_SW     = 3;
  localparam int unsigned PU_PHYREQ = 4;
  localparam int unsigned PU_BCR    = 5;
  localparam int unsigned PU_ENTRY  = 6;
  localparam int unsigned NUM_PULSE = 7;

  typedef struct packed {
    logic por;
    logic host;
    logic d3;
    logic d3phy;
    logic sw;
    logic phy;
  } src_t;

  // reset map: source set -> per-line assert request
  function automatic logic [NUM_RST-1:0] rst_map(src_t s, logic cold_wake);
    logic [NUM_RST-1:0] m;
    logic base;
    base        = s.por | s.host;
    m[IDX_WAKE] = s.por | (s.host & ~cold_wake);
    m[IDX_PHY]  = base | s.d3phy | s.phy;
    m[IDX_EEP]  = base;
    m[IDX_ID]   = base;
    m[IDX_CFG]  = base | s.d3;
    m[IDX_NASR] = base | s.d3;
    m[IDX_MAC]  = base | s.d3 | s.sw;
    m[IDX_DMA]  = base | s.d3 | s.sw;
    m[IDX_SYS]  = base | s.d3 | s.sw;
    return m;
  endfunction

endpackage

// File: rtl/pm_bit_sync.sv
module pm_bit_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pm_por_timer.sv
module pm_por_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  output logic por_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(CYCLES);

  logic [CW-1:0] cnt_q;
  logic          por_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      por_q <= 1'b1;
    end else if (!supply_ok_i) begin
      cnt_q <= '0;
      por_q <= 1'b1;
    end else if (cnt_q != CMAX) begin
      cnt_q <= cnt_q + 1'b1;
      por_q <= 1'b1;
    end else begin
      por_q <= 1'b0;
    end
  end

  assign por_o = por_q;
endmodule

// File: rtl/pm_rst_pulse.sv
module pm_rst_pulse #(
  parameter int unsigned LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic act_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (trig_i) begin
      cnt_q <= LOAD;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/pm_rst_out_sync.sv
module pm_rst_out_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic s1_q, s2_q;

  // assert async, release after two edges
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_no = s2_q;
endmodule

// File: rtl/pm_reset_ctrl.sv
module pm_reset_ctrl
  import pm_rst_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 125,
  parameter int unsigned POR_US       = 21000,
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       main_pwr_ok_i,
  input  logic       aux_pwr_ok_i,
  input  logic       aux_mode_i,
  input  logic       host_rst_ni,
  input  logic [1:0] pwr_state_i,
  input  logic       cold_wake_en_i,
  input  logic       phy_off_d3_i,
  input  logic       sw_rst_set_i,
  input  logic       phy_rst_set_i,
  input  logic       phy_bcr_wr_i,
  input  logic       phy_bcr_bit15_i,
  output logic       sw_pend_o,
  output logic       phy_pend_o,
  output logic       wake_rst_no,
  output logic       phy_rst_no,
  output logic       eep_rst_no,
  output logic       cfg_rst_no,
  output logic       mac_rst_no,
  output logic       dma_rst_no,
  output logic       sysreg_rst_no,
  output logic       nasr_rst_no,
  output logic       id_rst_no
);
  localparam int unsigned POR_CYCLES = CLK_MHZ * POR_US;

  logic main_ok_s, aux_ok_s, host_s, supply_ok, por_act;

  pm_bit_sync #(.RST_VAL(1'b0)) u_sync_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(main_pwr_ok_i), .q_o(main_ok_s));
  pm_bit_sync #(.RST_VAL(1'b0)) u_sync_aux (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(aux_pwr_ok_i), .q_o(aux_ok_s));
  pm_bit_sync #(.RST_VAL(1'b1)) u_sync_host (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(host_rst_ni), .q_o(host_s));

  assign supply_ok = aux_mode_i ? aux_ok_s : main_ok_s;

  pm_por_timer #(.CYCLES(POR_CYCLES)) u_por (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .por_o(por_act));

  pstate_e st, st_q;
  logic    in_d0, in_d3;
  logic    host_q, host_lvl_q, phy_flag_q;
  logic    host_rise, d3_exit, d3_entry, d3_leave;

  assign st    = pstate_e'(pwr_state_i);
  assign in_d0 = (st == PS_D0U) || (st == PS_D0A);
  assign in_d3 = !in_d0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_q     <= 1'b1;
      host_lvl_q <= 1'b0;
      st_q       <= PS_D0U;
    end else begin
      host_q     <= host_s;
      host_lvl_q <= !host_s && in_d0;
      st_q       <= st;
    end
  end

  assign host_rise = host_s && !host_q && in_d3;
  assign d3_entry  = (st_q != PS_D3H) && (st == PS_D3H);
  assign d3_leave  = (st_q == PS_D3H) && (st != PS_D3H);
  assign d3_exit   = (st_q == PS_D3H) && (st == PS_D0U);

  // remembers whether the PHY was reset on entry to D3 hot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phy_flag_q <= 1'b0;
    else if (por_act)   phy_flag_q <= 1'b0;
    else if (d3_entry)  phy_flag_q <= phy_off_d3_i;
    else if (d3_leave)  phy_flag_q <= 1'b0;
  end

  logic [NUM_PULSE-1:0] trig, act;

  assign trig[PU_HOST]   = host_rise;
  assign trig[PU_D3]     = d3_exit;
  assign trig[PU_D3PHY]  = d3_exit && phy_flag_q;
  assign trig[PU_SW]     = sw_rst_set_i;
  assign trig[PU_PHYREQ] = phy_rst_set_i;
  assign trig[PU_BCR]    = phy_bcr_wr_i && phy_bcr_bit15_i;
  assign trig[PU_ENTRY]  = d3_entry && phy_off_d3_i;

  for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
    pm_rst_pulse #(.LEN(PULSE_CYCLES)) u_pulse (
      .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig[g]), .act_o(act[g]));
  end

  src_t              src;
  logic [NUM_RST-1:0] rst_req, arst_n, rst_n;

  always_comb begin
    src.por   = por_act;
    src.host  = host_lvl_q | act[PU_HOST];
    src.d3    = act[PU_D3];
    src.d3phy = act[PU_D3PHY];
    src.sw    = act[PU_SW];
    src.phy   = act[PU_PHYREQ] | act[PU_BCR] | act[PU_ENTRY];
  end

  assign rst_req = rst_map(src, cold_wake_en_i);

  for (genvar g = 0; g < NUM_RST; g++) begin : g_out
    assign arst_n[g] = rst_ni & ~rst_req[g];
    pm_rst_out_sync u_osync (
      .clk_i(clk_i), .arst_ni(arst_n[g]), .rst_no(rst_n[g]));
  end

  assign wake_rst_no   = rst_n[IDX_WAKE];
  assign phy_rst_no    = rst_n[IDX_PHY];
  assign eep_rst_no    = rst_n[IDX_EEP];
  assign cfg_rst_no    = rst_n[IDX_CFG];
  assign mac_rst_no    = rst_n[IDX_MAC];
  assign dma_rst_no    = rst_n[IDX_DMA];
  assign sysreg_rst_no = rst_n[IDX_SYS];
  assign nasr_rst_no   = rst_n[IDX_NASR];
  assign id_rst_no     = rst_n[IDX_ID];

  assign sw_pend_o  = act[PU_SW];
  assign phy_pend_o = act[PU_PHYREQ];
endmodule

// File: rtl/pm_reset_ctrl_chk.sv
module pm_reset_ctrl_chk
  import pm_rst_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               por_act_i,
  input logic               host_lvl_i,
  input logic               sw_pend_i,
  input logic               phy_pend_i,
  input logic [NUM_RST-1:0] rst_n_i
);
  p_por_all_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_act_i |-> rst_n_i == '0);

  p_host_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_lvl_i |-> !rst_n_i[IDX_MAC] && !rst_n_i[IDX_ID] && !rst_n_i[IDX_EEP]);

  p_sw_lines_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_pend_i |-> !rst_n_i[IDX_MAC] && !rst_n_i[IDX_DMA] && !rst_n_i[IDX_SYS]);

  p_sw_min_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_pend_i) |=> sw_pend_i);

  p_phy_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_pend_i |-> !rst_n_i[IDX_PHY]);

  p_release_lag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_n_i[IDX_MAC]) |-> !$past(sw_pend_i));
endmodule

bind pm_reset_ctrl pm_reset_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .por_act_i (por_act),
  .host_lvl_i(host_lvl_q),
  .sw_pend_i (sw_pend_o),
  .phy_pend_i(phy_pend_o),
  .rst_n_i   ({id_rst_no, nasr_rst_no, sysreg_rst_no, dma_rst_no, mac_rst_no,
                cfg_rst_no, eep_rst_no, phy_rst_no, wake_rst_no})
);

// File: tb/sim_pm_reset_ctrl.sv
module sim_pm_reset_ctrl;
  // mask bit order: 0 wake,1 phy,2 eep,3 cfg,4 mac,5 dma,6 sys,7 nasr,8 id
  localparam logic [2:0] A_HLOW  = 3'd0;
  localparam logic [2:0] A_HRISE = 3'd1;
  localparam logic [2:0] A_SW    = 3'd2;
  localparam logic [2:0] A_PHY   = 3'd3;
  localparam logic [2:0] A_BCR1  = 3'd4;
  localparam logic [2:0] A_BCR0  = 3'd5;
  localparam logic [2:0] A_D3X   = 3'd6;
  localparam logic [2:0] A_D3E   = 3'd7;

  typedef struct packed {
    logic [1:0] st;
    logic       cold;
    logic       phyoff;
    logic [2:0] act;
    logic [8:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b0, 1'b0, A_HLOW,  9'h1FF, 4'd2},  // R2
    '{2'd0, 1'b1, 1'b0, A_HLOW,  9'h1FE, 4'd8},  // R8 with R2
    '{2'd2, 1'b0, 1'b0, A_HLOW,  9'h000, 4'd3},  // R3 level ignored
    '{2'd3, 1'b0, 1'b0, A_HRISE, 9'h1FF, 4'd3},  // R3 edge pulse
    '{2'd2, 1'b1, 1'b0, A_HRISE, 9'h1FE, 4'd8},  // R8 in D3
    '{2'd1, 1'b0, 1'b0, A_HRISE, 9'h000, 4'd2},  // R2 release
    '{2'd1, 1'b0, 1'b0, A_SW,    9'h070, 4'd5},  // R5
    '{2'd1, 1'b0, 1'b0, A_PHY,   9'h002, 4'd6},  // R6
    '{2'd1, 1'b0, 1'b0, A_BCR1,  9'h002, 4'd7},  // R7
    '{2'd1, 1'b0, 1'b0, A_BCR0,  9'h000, 4'd7},  // R7 bit15 clear
    '{2'd2, 1'b0, 1'b0, A_D3X,   9'h0F8, 4'd4},  // R4
    '{2'd2, 1'b0, 1'b1, A_D3X,   9'h0FA, 4'd9},  // R9 exit
    '{2'd2, 1'b0, 1'b1, A_D3E,   9'h002, 4'd9},  // R9 entry
    '{2'd2, 1'b0, 1'b0, A_D3E,   9'h000, 4'd9},  // R9 no entry reset
    '{2'd3, 1'b0, 1'b0, A_SW,    9'h070, 4'd5},  // R5 in D3
    '{2'd3, 1'b1, 1'b0, A_HLOW,  9'h000, 4'd3}   // R3
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic main_ok = 1'b0, aux_ok = 1'b0, aux_mode = 1'b0, host_n = 1'b1;
  logic [1:0] pstate = 2'd1;
  logic cold = 1'b0, phyoff = 1'b0, sw_set = 1'b0, phy_set = 1'b0;
  logic bcr_wr = 1'b0, bcr_b15 = 1'b0;
  logic sw_pend, phy_pend;
  logic wake_n, phy_n, eep_n, cfg_n, mac_n, dma_n, sys_n, nasr_n, id_n;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pm_reset_ctrl #(.CLK_MHZ(125), .POR_US(1), .PULSE_CYCLES(16)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .main_pwr_ok_i(main_ok), .aux_pwr_ok_i(aux_ok),
    .aux_mode_i(aux_mode), .host_rst_ni(host_n), .pwr_state_i(pstate),
    .cold_wake_en_i(cold), .phy_off_d3_i(phyoff), .sw_rst_set_i(sw_set),
    .phy_rst_set_i(phy_set), .phy_bcr_wr_i(bcr_wr), .phy_bcr_bit15_i(bcr_b15),
    .sw_pend_o(sw_pend), .phy_pend_o(phy_pend), .wake_rst_no(wake_n),
    .phy_rst_no(phy_n), .eep_rst_no(eep_n), .cfg_rst_no(cfg_n), .mac_rst_no(mac_n),
    .dma_rst_no(dma_n), .sysreg_rst_no(sys_n), .nasr_rst_no(nasr_n), .id_rst_no(id_n));

  function automatic logic [8:0] mask();
    return ~{id_n, nasr_n, sys_n, dma_n, mac_n, cfg_n, eep_n, phy_n, wake_n};
  endfunction

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R1 reset state", mask(), 9'h1FF);
    rst_ni = 1'b1;
    cyc(20);
    chk("R1 supply low", mask(), 9'h1FF);
    main_ok = 1'b1;
    cyc(100);
    chk("R1 still counting", mask(), 9'h1FF);
    cyc(60);
    chk("R1 released", mask(), 9'h000);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      cold   = v.cold;
      phyoff = v.phyoff;
      if (v.act == A_D3X || v.act == A_D3E) begin
        pstate = 2'd1;
        cyc(40);
        if (v.act == A_D3X) begin
          pstate = 2'd2;
          cyc(40);
        end
      end else begin
        pstate = v.st;
        cyc(40);
      end
      case (v.act)
        A_HLOW:  begin host_n = 1'b0; cyc(8); end
        A_HRISE: begin host_n = 1'b0; cyc(10); host_n = 1'b1; cyc(8); end
        A_SW:    begin sw_set = 1'b1; cyc(1); sw_set = 1'b0; cyc(5); end
        A_PHY:   begin phy_set = 1'b1; cyc(1); phy_set = 1'b0; cyc(5); end
        A_BCR1:  begin bcr_wr = 1'b1; bcr_b15 = 1'b1; cyc(1); bcr_wr = 1'b0; bcr_b15 = 1'b0; cyc(5); end
        A_BCR0:  begin bcr_wr = 1'b1; bcr_b15 = 1'b0; cyc(1); bcr_wr = 1'b0; cyc(5); end
        A_D3X:   begin pstate = 2'd0; cyc(6); end
        default: begin pstate = 2'd2; cyc(6); end
      endcase
      chk($sformatf("R%0d vector %0d", v.req, i), mask(), v.exp);
      host_n = 1'b1;
      cyc(40);
    end

    cold = 1'b0;
    phyoff = 1'b0;
    pstate = 2'd1;
    cyc(40);
    chk("R2 idle after table", mask(), 9'h000);

    // R10 and R5: exact assert/release cycles of a software pulse
    sw_set = 1'b1;
    cyc(1);
    sw_set = 1'b0;
    chk("R10 async assert", {8'h0, mac_n}, 9'h000);
    chk("R5 pend set", {8'h0, sw_pend}, 9'h001);
    cyc(15);
    chk("R5 pend last cycle", {8'h0, sw_pend}, 9'h001);
    cyc(1);
    chk("R5 pend self-clear", {8'h0, sw_pend}, 9'h000);
    cyc(1);
    chk("R10 still held", {8'h0, mac_n}, 9'h000);
    cyc(1);
    chk("R10 released after two edges", {8'h0, mac_n}, 9'h001);
    chk("R5 nasr untouched", {8'h0, nasr_n}, 9'h001);

    // R6 self-clearing PHY bit
    phy_set = 1'b1;
    cyc(1);
    phy_set = 1'b0;
    chk("R6 pend set", {8'h0, phy_pend}, 9'h001);
    cyc(16);
    chk("R6 pend self-clear", {8'h0, phy_pend}, 9'h000);
    cyc(10);

    // R4: D3 cold to D0 uninitialized fires nothing
    pstate = 2'd3;
    cyc(40);
    pstate = 2'd0;
    cyc(6);
    chk("R4 D3 cold exit", mask(), 9'h000);
    cyc(30);

    // R1: auxiliary supply selection
    aux_mode = 1'b1;
    cyc(10);
    chk("R1 aux supply low", mask(), 9'h1FF);
    aux_ok = 1'b1;
    cyc(200);
    chk("R1 aux supply good", mask(), 9'h000);

    finish_run();
  end
endmodule